// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Software reaches it through a simple synchronous word-addressed register port. The block drives an output value and an output enable for every pin. It samples every pin input through a synchronizer and records selected input transitions in sticky status bits. A single interrupt line is raised whenever any status bit is set.

The registers are grouped by feature, not by pin word. Each feature holds `NUM_PINS/32` consecutive 32-bit words. The output value is never written directly. It changes only through a write-one-to-set bank and a write-one-to-clear bank, so software can update single pins without a read-modify-write. A status bit is cleared by writing a one to it. An edge that arrives in the same cycle as its clear is still recorded.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The word address of word w of feature f is f·N + w, where N = NUM_PINS/32. The feature order is: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status. Pin p sits in word p/32 at bit p%32.
- R2: The level bank returns each pin input after a two-stage synchronizer. The level bank is read-only, so writes to it change nothing.
- R3: A direction bit of 1 drives `pin_oe` high for that pin and a 0 makes the pin an input. Direction resets to all zeros.
- R4: Writing a 1 to a set-bank bit drives that pin's `pin_out` high, and writing a 1 to a clear-bank bit drives it low. Zero bits in either write leave the pin unchanged. Both banks read back as zero, and `pin_out` resets to zero.
- R5: The output latch keeps its value while the pin is an input. Set and clear writes still update it, and the stored value appears with the enable once the pin becomes an output.
- R6: With the rising enable set, a 0-to-1 transition of the synchronized input sets the pin's status bit. A 1-to-0 transition does not set it unless the falling enable is also set.
- R7: With the falling enable set, a 1-to-0 transition sets the status bit. With both enables set, either transition sets it.
- R8: A status bit stays set until software writes a 1 to it. Writing a 0 leaves it unchanged.
- R9: If an enabled edge and a write-one clear of the same status bit fall in the same cycle, the bit stays set.
- R10: `irq` is high exactly while at least one status bit in any word is set. It rises three clock edges after the pin input changes.
- R11: Reads of addresses at or above 7·N return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe, held until the next read |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Per-pin output enables |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench sends a status clear so that it lands in the same cycle as a new falling edge on the same pin. A design where the clear takes priority would lose that edge and read back zero. It checks that `irq` is still low two edges after a pin change and high on the third. A synchronizer that is too short or too long fails that check. It sets a pin's output latch while the pin is still an input and then turns the output on, which catches a design that gates the latch with the direction bit. It also checks that a zero written to the status bank does not clear a bit, that a rising-only pin ignores falling edges, and that writes to the level bank or to unmapped addresses leave the enables and outputs untouched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int WORD_W   = 32;
   localparam int NUM_FEAT = 7;

   // feature order fixes the address map
   typedef enum logic [2:0] {
      FEAT_LEVEL = 3'd0,
      FEAT_DIR   = 3'd1,
      FEAT_SET   = 3'd2,
      FEAT_CLR   = 3'd3,
      FEAT_RISE  = 3'd4,
      FEAT_FALL  = 3'd5,
      FEAT_STAT  = 3'd6
   } gpio_feat_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
   parameter int NSLOT  = 14,
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NSLOT-1:0]  slot_hit
);
   // one-hot slot select; addresses beyond NSLOT select nothing
   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         assign slot_hit[s] = (int'(addr) == s);
      end
   endgenerate
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] rise_p,
   output logic [WIDTH-1:0] fall_p
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;
   logic [WIDTH-1:0]             prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= pin_in;
   end

   generate
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[k] <= '0;
            else        chain_q[k] <= chain_q[k-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level  = chain_q[STAGES-1];
   assign rise_p = level & ~prev_q;
   assign fall_p = ~level & prev_q;
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rise_p,
   input  logic [WIDTH-1:0] fall_p,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] stat,
   output logic [WIDTH-1:0] hit
);
   assign hit = (rise_p & rise_en) | (fall_p & fall_en);

   // clear first, then a fresh hit re-sets: no edge is lost
   always_ff @(posedge clk) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr_mask) | hit;
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = $clog2(NUM_FEAT * (NUM_PINS / WORD_W))
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   localparam int NWORDS = NUM_PINS / WORD_W;
   localparam int NSLOT  = NUM_FEAT * NWORDS;

   generate
      if (NUM_PINS < WORD_W || (NUM_PINS % WORD_W) != 0) begin : g_bad_pins
         $error("NUM_PINS must be a positive multiple of 32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((1 << ADDR_W) < NSLOT) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic                                wstb, rstb;
   logic [NSLOT-1:0]                    slot_hit;
   logic [NUM_PINS-1:0]                 wdata_rep;
   logic [NUM_FEAT-1:0][NUM_PINS-1:0]   word_wen;
   logic [NUM_FEAT-1:0][NUM_PINS-1:0]   bank_view;
   logic [NUM_PINS-1:0]                 set_mask, clr_mask, sclr_mask, dir_wen;
   logic [NUM_PINS-1:0]                 dir_q, out_q, ren_q, fen_q;
   logic [NUM_PINS-1:0]                 lvl, rise_p, fall_p;
   logic [NUM_PINS-1:0]                 stat_all, hit_all;
   logic [WORD_W-1:0]                   rd_word;

   assign wstb      = bus_sel & bus_we;
   assign rstb      = bus_sel & ~bus_we;
   assign wdata_rep = {NWORDS{bus_wdata}};

   gpio_addr_dec #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_dec (
      .addr     (bus_addr),
      .slot_hit (slot_hit)
   );

   // per-feature, per-word write enables spread to pin width
   generate
      for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
         for (genvar w = 0; w < NWORDS; w++) begin : g_word
            assign word_wen[f][w*WORD_W +: WORD_W] =
               {WORD_W{wstb & slot_hit[f*NWORDS + w]}};
         end
      end
   endgenerate

   assign dir_wen   = word_wen[int'(FEAT_DIR)];
   assign set_mask  = word_wen[int'(FEAT_SET)]  & wdata_rep;
   assign clr_mask  = word_wen[int'(FEAT_CLR)]  & wdata_rep;
   assign sclr_mask = word_wen[int'(FEAT_STAT)] & wdata_rep;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         ren_q <= '0;
         fen_q <= '0;
      end else begin
         dir_q <= (dir_q & ~dir_wen) | (wdata_rep & dir_wen);
         ren_q <= (ren_q & ~word_wen[int'(FEAT_RISE)]) |
                  (wdata_rep & word_wen[int'(FEAT_RISE)]);
         fen_q <= (fen_q & ~word_wen[int'(FEAT_FALL)]) |
                  (wdata_rep & word_wen[int'(FEAT_FALL)]);
         out_q <= (out_q | set_mask) & ~clr_mask;
      end
   end

   gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .level  (lvl),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   generate
      for (genvar w = 0; w < NWORDS; w++) begin : g_edge
         gpio_edge_word #(.WIDTH(WORD_W)) u_ew (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_p   (rise_p[w*WORD_W +: WORD_W]),
            .fall_p   (fall_p[w*WORD_W +: WORD_W]),
            .rise_en  (ren_q[w*WORD_W +: WORD_W]),
            .fall_en  (fen_q[w*WORD_W +: WORD_W]),
            .clr_mask (sclr_mask[w*WORD_W +: WORD_W]),
            .stat     (stat_all[w*WORD_W +: WORD_W]),
            .hit      (hit_all[w*WORD_W +: WORD_W])
         );
      end
   endgenerate

   // readable view of each bank; set and clear read as zero
   assign bank_view[int'(FEAT_LEVEL)] = lvl;
   assign bank_view[int'(FEAT_DIR)]   = dir_q;
   assign bank_view[int'(FEAT_SET)]   = '0;
   assign bank_view[int'(FEAT_CLR)]   = '0;
   assign bank_view[int'(FEAT_RISE)]  = ren_q;
   assign bank_view[int'(FEAT_FALL)]  = fen_q;
   assign bank_view[int'(FEAT_STAT)]  = stat_all;

   always_comb begin
      rd_word = '0;
      for (int f = 0; f < NUM_FEAT; f++) begin
         for (int w = 0; w < NWORDS; w++) begin
            if (slot_hit[f*NWORDS + w])
               rd_word = rd_word | bank_view[f][w*WORD_W +: WORD_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    bus_rdata <= '0;
      else if (rstb) bus_rdata <= rd_word;
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign irq     = |stat_all;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int NUM_PINS = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq,
   input logic [NUM_PINS-1:0] stat,
   input logic [NUM_PINS-1:0] hit,
   input logic [NUM_PINS-1:0] set_m,
   input logic [NUM_PINS-1:0] clr_m,
   input logic [NUM_PINS-1:0] sclr_m,
   input logic [NUM_PINS-1:0] dir_wen
);
   // R4: set-bank ones reach the output latch
   a_r4_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & $past(set_m)) == $past(set_m));

   // R4: clear-bank ones pull the output latch low
   a_r4_clr_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & $past(clr_m)) == '0);

   // R3: enables move only on a direction write
   a_r3_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dir_wen) == '0) |-> $stable(pin_oe));

   // R8: a set status bit survives unless its clear bit was written
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) & ~$past(sclr_m) & ~stat) == '0);

   // R9: every detected edge lands in status, even against a clear
   a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (stat & $past(hit)) == $past(hit));

   // R10: the interrupt only rises after an edge was detected
   a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(hit) != '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pin_out (pin_out),
   .pin_oe  (pin_oe),
   .irq     (irq),
   .stat    (stat_all),
   .hit     (hit_all),
   .set_m   (set_mask),
   .clr_m   (clr_mask),
   .sclr_m  (sclr_mask),
   .dir_wen (dir_wen)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
   localparam int NP = 64;
   localparam int AW = 4;
   // word addresses for NP=64 (two words per feature)
   localparam int A_LVL = 0, A_DIR = 2, A_SET = 4, A_CLR = 6;
   localparam int A_RISE = 8, A_FALL = 10, A_STAT = 12, A_NONE = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [NP-1:0] exp_oe = '0, exp_out = '0;

   always #2 clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R3 reset oe", pin_oe, '0);
      chk("R4 reset out", pin_out, '0);
      chk("R10 reset irq", {63'd0, irq}, 64'd0);
      rd(A_DIR, d);
      chk("R3 reset dir read", {32'd0, d}, 64'd0);
   endtask

   task automatic t_level;
      logic [31:0] d;
      pin_in = 64'hA5C3_0F00_1234_5678;
      idle(2);
      rd(A_LVL, d);
      chk("R2 level word0", {32'd0, d}, 64'h1234_5678);
      rd(A_LVL + 1, d);
      chk("R1 level word1", {32'd0, d}, 64'hA5C3_0F00);
      pin_in = '0;
      idle(4);
   endtask

   task automatic t_dir;
      logic [31:0] d;
      wr(A_DIR + 1, 32'h0000_FF00);
      exp_oe[47:40] = 8'hFF;
      chk("R1 dir word1 bit map", pin_oe, exp_oe);
      rd(A_DIR + 1, d);
      chk("R3 dir readback", {32'd0, d}, 64'h0000_FF00);
   endtask

   task automatic t_setclr;
      logic [31:0] d;
      wr(A_SET, 32'h0000_00F0);
      exp_out[7:4] = 4'hF;
      chk("R4 set bank", pin_out, exp_out);
      wr(A_CLR, 32'h0000_0030);
      exp_out[5:4] = 2'b00;
      chk("R4 clear bank zeros ignored", pin_out, exp_out);
      wr(A_SET + 1, 32'h0000_0100);
      exp_out[40] = 1'b1;
      chk("R4 set word1 pin 40", pin_out, exp_out);
      rd(A_SET, d);
      chk("R4 set reads zero", {32'd0, d}, 64'd0);
      rd(A_CLR + 1, d);
      chk("R4 clear reads zero", {32'd0, d}, 64'd0);
   endtask

   task automatic t_latch_hold;
      wr(A_SET, 32'h0000_0004);
      exp_out[2] = 1'b1;
      chk("R5 latch updates while input", pin_out, exp_out);
      chk("R5 pin 2 still input", pin_oe, exp_oe);
      wr(A_DIR, 32'h0000_0004);
      exp_oe[2] = 1'b1;
      chk("R5 oe after dir", pin_oe, exp_oe);
      chk("R5 latch value kept", pin_out, exp_out);
   endtask

   task automatic t_rise;
      logic [31:0] d;
      wr(A_RISE + 1, 32'h0000_0002);       // pin 33 rising
      pin_in[33] = 1'b1;
      idle(2);
      chk("R10 irq not before third edge", {63'd0, irq}, 64'd0);
      idle(1);
      chk("R10 irq after third edge", {63'd0, irq}, 64'd1);
      rd(A_STAT + 1, d);
      chk("R6 rising status", {32'd0, d}, 64'h2);
      wr(A_STAT + 1, 32'h0000_0002);
      chk("R8 W1C clears irq", {63'd0, irq}, 64'd0);
      pin_in[33] = 1'b0;
      idle(4);
      rd(A_STAT + 1, d);
      chk("R6 falling ignored on rise-only pin", {32'd0, d}, 64'd0);
      chk("R10 irq low", {63'd0, irq}, 64'd0);
   endtask

   task automatic t_both;
      logic [31:0] d;
      wr(A_RISE, 32'h0000_0008);
      wr(A_FALL, 32'h0000_0008);           // pin 3 both edges
      pin_in[3] = 1'b1;
      idle(4);
      wr(A_STAT, 32'h0000_0000);
      rd(A_STAT, d);
      chk("R8 zero write keeps status", {32'd0, d}, 64'h8);
      wr(A_STAT, 32'h0000_0008);
      rd(A_STAT, d);
      chk("R8 W1C clears", {32'd0, d}, 64'h0);
      pin_in[3] = 1'b0;
      idle(4);
      rd(A_STAT, d);
      chk("R7 falling captured", {32'd0, d}, 64'h8);
      wr(A_STAT, 32'h0000_0008);
   endtask

   task automatic t_collide;
      logic [31:0] d;
      pin_in[3] = 1'b1;
      idle(4);
      pin_in[3] = 1'b0;                    // fall hit sits before third edge
      idle(2);
      wr(A_STAT, 32'h0000_0008);           // clear captured at that edge
      rd(A_STAT, d);
      chk("R9 edge beats clear", {32'd0, d}, 64'h8);
      chk("R10 irq held", {63'd0, irq}, 64'd1);
      wr(A_STAT, 32'h0000_0008);
      chk("R10 irq released", {63'd0, irq}, 64'd0);
   endtask

   task automatic t_ignored;
      logic [31:0] d;
      wr(A_NONE, 32'hFFFF_FFFF);
      wr(A_NONE + 1, 32'hFFFF_FFFF);
      chk("R11 unmapped write oe", pin_oe, exp_oe);
      chk("R11 unmapped write out", pin_out, exp_out);
      rd(A_NONE, d);
      chk("R11 unmapped reads zero", {32'd0, d}, 64'd0);
      wr(A_LVL, 32'hFFFF_FFFF);
      chk("R2 level write no oe change", pin_oe, exp_oe);
      chk("R2 level write no out change", pin_out, exp_out);
      rd(A_LVL, d);
      chk("R2 level read-only", {32'd0, d}, 64'd0);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level();
      t_dir();
      t_setclr();
      t_latch_hold();
      t_rise();
      t_both();
      t_collide();
      t_ignored();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end
endmodule